// File: doc/BRIEF.md
# Two-Level Page Translation Unit with Recent-Translation Cache

This block turns 32-bit linear addresses into physical addresses using 4 KB pages. A small fully associative cache remembers the 32 page translations used most recently. A request that hits this cache, or any request made while translation is switched off, is answered in the same clock cycle it is accepted. A request that misses starts a walk. The walk reads one entry from the page directory and then one entry from the page table that the directory entry points to, through a simple memory read port. It then stores the translation in the cache and returns the result.

Software-level state reaches the block through only a few inputs. One input turns translation on or off. A 20-bit register load gives the directory's physical frame, and loading it also empties the cache. A separate pulse empties the cache without changing the frame. Only one request is outstanding at a time. While a walk is in progress, `req_ready` stays low.

Top module: `pgx_translator`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `mem_req` is 0, the directory frame is 0, and the cache holds no translations, so the first translated request walks.
- R2: While `xlate_en` is 0, an accepted request is answered in its accept cycle with `rsp_phys` equal to `req_lin` and `rsp_fault` 0. It causes no memory read and does not change the cache.
- R3: On a miss, the first memory read is at {frame[19:0], lin[31:22], 2'b00}. If that entry has bit 0 (present) set, the second read is at {entry[31:12], lin[21:12], 2'b00}. `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen.
- R4: A completed walk whose table entry has bit 0 set answers with `rsp_phys` = {table_entry[31:12], lin[11:0]} and `rsp_fault` 0, in a one-cycle response, and stores the translation.
- R5: A request whose page is cached is answered in its accept cycle with the cached frame and the unchanged low 12 address bits. It causes no memory read.
- R6: If bit 0 is clear in the directory entry (after 1 read) or in the table entry (after 2 reads), the response has `rsp_fault` 1 and `rsp_phys` 0, and nothing is stored. Repeating the request walks again.
- R7: The cache holds 32 translations and replaces the least recently used one. Both a hit and a new fill count as use.
- R8: A `flush` pulse invalidates every cached translation. A walk that is in flight when the pulse arrives still answers but does not store its result.
- R9: A `dir_base_wr` pulse loads `dir_base_in` as the directory frame and invalidates every cached translation. Later walks read from the new frame.
- R10: From the cycle after a miss is accepted until its response cycle, `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlate_en | input | 1 | Translation enable; 0 passes addresses through |
| dir_base_wr | input | 1 | Load pulse for the directory frame; also invalidates the cache |
| dir_base_in | input | 20 | New directory frame (physical address bits 31:12) |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Translation request present |
| req_lin | input | 32 | Linear address to translate |
| req_ready | output | 1 | Request can be accepted this cycle |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_phys | output | 32 | Physical address result |
| rsp_fault | output | 1 | Page fault: an entry was not present |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_data | input | 32 | Entry returned by memory |

## Verification
The embedded properties check the following in every cycle:
- the pass-through result while translation is off;
- that the page offset survives on same-cycle answers;
- that a memory request is held with a steady address until acknowledged;
- that at most one cache entry matches a page;
- that nothing hits in the cycle after a flush;
- that a walk's response lasts exactly one cycle.

Only the scenarios in the bench can show some other behaviours:
- the least-recently-used choice of victim;
- that a fault leaves nothing cached;
- the exact read addresses of a walk;
- that loading a new directory frame redirects later walks.

The bench shows these by counting and logging memory reads per request, against a reference walk over its own page tables.

// File: rtl/pgx_pkg.sv
// Package: shared widths and the walk state type for the translation unit.
// Assumes 32-bit linear and physical addresses with 4 KB pages.
package pgx_pkg;
    localparam int ADDR_W  = 32;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 10;
    localparam int PAGE_W  = ADDR_W - OFF_W;
    localparam int ENTRY_W = 32;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_DIR  = 2'd1,
        WK_TBL  = 2'd2,
        WK_RESP = 2'd3
    } walk_state_e;
endpackage

// File: rtl/pgx_tlb.sv
// Module: fully associative cache of page translations with LRU replacement.
// Each entry carries an age; ages form a permutation of 0..ENTRIES-1 and
// the entry of age ENTRIES-1 is the oldest. Invalid entries are filled first.
// Assumes ENTRIES is a power of two. A flush wins over a same-cycle fill.
module pgx_tlb
    import pgx_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [PAGE_W-1:0] lk_page,
    input  logic              lk_use,
    output logic              lk_hit,
    output logic [PAGE_W-1:0] lk_frame,
    input  logic              ins_en,
    input  logic [PAGE_W-1:0] ins_page,
    input  logic [PAGE_W-1:0] ins_frame
);
    localparam int AGE_W = $clog2(ENTRIES);
    localparam logic [AGE_W-1:0] AGE_OLDEST = AGE_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] valid_q;
    logic [PAGE_W-1:0]  tag_q   [ENTRIES];
    logic [PAGE_W-1:0]  frame_q [ENTRIES];
    logic [AGE_W-1:0]   age_q   [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic [AGE_W-1:0]   hit_idx;
    logic [AGE_W-1:0]   victim_idx;
    logic [AGE_W-1:0]   use_idx;
    logic               use_en;

    // Per-entry tag comparators.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_page);
    end

    // Encode the matching entry and select its frame.
    always_comb begin
        hit_idx  = '0;
        lk_frame = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = AGE_W'(i);
            lk_frame = lk_frame | ({PAGE_W{hit_vec[i]}} & frame_q[i]);
        end
    end
    assign lk_hit = |hit_vec;

    // Victim: lowest-numbered invalid entry, otherwise the oldest entry.
    always_comb begin
        logic found_free;
        found_free = 1'b0;
        victim_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                victim_idx = AGE_W'(i);
                found_free = 1'b1;
            end
        end
        if (!found_free) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (age_q[i] == AGE_OLDEST) victim_idx = AGE_W'(i);
            end
        end
    end

    assign use_idx = ins_en ? victim_idx : hit_idx;
    assign use_en  = ins_en || (lk_use && lk_hit);

    // Valid bits: reset and flush clear all, a fill sets the victim.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= '0;
        end else if (ins_en) begin
            valid_q[victim_idx] <= 1'b1;
        end
    end

    // Tag and frame storage written on fill.
    always_ff @(posedge clk) begin
        if (ins_en && !flush) begin
            tag_q[victim_idx]   <= ins_page;
            frame_q[victim_idx] <= ins_frame;
        end
    end

    // Age update: the used entry becomes youngest, younger ones age by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= AGE_W'(i);
        end else if (use_en && !flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (AGE_W'(i) == use_idx) age_q[i] <= '0;
                else if (age_q[i] < age_q[use_idx]) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    // At most one entry may match any page (R5).
    p_unique_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // Nothing hits in the cycle after a flush (R8).
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);
endmodule

// File: rtl/pgx_walker.sv
// Module: two-step walk engine. Reads the directory entry, then the table
// entry, over a request/acknowledge read port, and produces a one-cycle
// response. Assumes mem_ack comes only while mem_req is high. A kill
// (flush or new frame) during a walk stops the result from being stored.
module pgx_walker
    import pgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_lin,
    input  logic [PAGE_W-1:0] dir_frame,
    input  logic              kill,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [ENTRY_W-1:0] mem_data,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] done_phys,
    output logic              done_fault,
    output logic              ins_en,
    output logic [PAGE_W-1:0] ins_page,
    output logic [PAGE_W-1:0] ins_frame
);
    walk_state_e       state_q;
    logic [ADDR_W-1:0] lin_q;
    logic [PAGE_W-1:0] tbl_frame_q;
    logic              stale_q;
    logic              present;
    logic [10:0]       unused_attr;

    assign present     = mem_data[0];
    assign unused_attr = mem_data[11:1];

    // Read address for the current step.
    always_comb begin
        mem_addr = '0;
        if (state_q == WK_DIR)
            mem_addr = {dir_frame, lin_q[ADDR_W-1 -: IDX_W], 2'b00};
        else if (state_q == WK_TBL)
            mem_addr = {tbl_frame_q, lin_q[OFF_W+IDX_W-1 -: IDX_W], 2'b00};
    end

    assign mem_req   = (state_q == WK_DIR) || (state_q == WK_TBL);
    assign busy      = (state_q != WK_IDLE);
    assign done      = (state_q == WK_RESP);
    assign ins_en    = (state_q == WK_TBL) && mem_ack && present && !stale_q && !kill;
    assign ins_page  = lin_q[ADDR_W-1:OFF_W];
    assign ins_frame = mem_data[ENTRY_W-1:OFF_W];

    // Walk sequencing and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= WK_IDLE;
            lin_q       <= '0;
            tbl_frame_q <= '0;
            stale_q     <= 1'b0;
            done_phys   <= '0;
            done_fault  <= 1'b0;
        end else begin
            case (state_q)
                WK_IDLE: begin
                    if (start) begin
                        lin_q   <= start_lin;
                        stale_q <= 1'b0;
                        state_q <= WK_DIR;
                    end
                end
                WK_DIR: begin
                    if (kill) stale_q <= 1'b1;
                    if (mem_ack) begin
                        if (present) begin
                            tbl_frame_q <= mem_data[ENTRY_W-1:OFF_W];
                            state_q     <= WK_TBL;
                        end else begin
                            done_phys  <= '0;
                            done_fault <= 1'b1;
                            state_q    <= WK_RESP;
                        end
                    end
                end
                WK_TBL: begin
                    if (kill) stale_q <= 1'b1;
                    if (mem_ack) begin
                        done_fault <= !present;
                        done_phys  <= present ? {mem_data[ENTRY_W-1:OFF_W], lin_q[OFF_W-1:0]} : '0;
                        state_q    <= WK_RESP;
                    end
                end
                default: state_q <= WK_IDLE;
            endcase
        end
    end

    // A read request is held with a steady address until acknowledged (R3).
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // A walk's response lasts exactly one cycle (R4).
    p_resp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/pgx_translator.sv
// Module: top of the translation unit. Holds the directory frame, looks up
// the translation cache, answers hits and pass-through in the accept cycle,
// and hands misses to the walker. One request outstanding at a time.
module pgx_translator
    import pgx_pkg::*;
#(
    parameter int TLB_ENTRIES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xlate_en,
    input  logic        dir_base_wr,
    input  logic [19:0] dir_base_in,
    input  logic        flush,
    input  logic        req_valid,
    input  logic [31:0] req_lin,
    output logic        req_ready,
    output logic        rsp_valid,
    output logic [31:0] rsp_phys,
    output logic        rsp_fault,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_data
);
    logic [PAGE_W-1:0] dir_frame_q;
    logic              accept, pass, hit_rsp, start, kill;
    logic              lk_hit;
    logic [PAGE_W-1:0] lk_frame;
    logic              busy, done, done_fault;
    logic [ADDR_W-1:0] done_phys;
    logic              ins_en;
    logic [PAGE_W-1:0] ins_page, ins_frame;

    // Directory frame register, loaded by its write pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)           dir_frame_q <= '0;
        else if (dir_base_wr) dir_frame_q <= dir_base_in;
    end

    assign kill      = flush || dir_base_wr;
    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign pass      = accept && !xlate_en;
    assign hit_rsp   = accept && xlate_en && lk_hit;
    assign start     = accept && xlate_en && !lk_hit;

    pgx_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (kill),
        .lk_page   (req_lin[ADDR_W-1:OFF_W]),
        .lk_use    (accept && xlate_en),
        .lk_hit    (lk_hit),
        .lk_frame  (lk_frame),
        .ins_en    (ins_en),
        .ins_page  (ins_page),
        .ins_frame (ins_frame)
    );

    pgx_walker u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_lin  (req_lin),
        .dir_frame  (dir_frame_q),
        .kill       (kill),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_data   (mem_data),
        .busy       (busy),
        .done       (done),
        .done_phys  (done_phys),
        .done_fault (done_fault),
        .ins_en     (ins_en),
        .ins_page   (ins_page),
        .ins_frame  (ins_frame)
    );

    // Response select: walk result, pass-through, or cached frame.
    always_comb begin
        rsp_valid = pass || hit_rsp || done;
        rsp_fault = done && done_fault;
        if (done)      rsp_phys = done_phys;
        else if (pass) rsp_phys = req_lin;
        else           rsp_phys = {lk_frame, req_lin[OFF_W-1:0]};
    end

    // Translation off: same-cycle answer equal to the request (R2).
    p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xlate_en) |-> (rsp_valid && rsp_phys == req_lin && !rsp_fault));

    // Same-cycle answers keep the page offset (R5).
    p_offset_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && req_ready && !rsp_fault) |-> (rsp_phys[11:0] == req_lin[11:0]));

    // Memory is only read while a walk holds off new requests (R10).
    p_walk_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);
endmodule

// File: tb/pgx_translator_bench.sv
module pgx_translator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_en = 1'b0;
    logic        dir_base_wr = 1'b0;
    logic [19:0] dir_base_in = '0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_lin = '0;
    logic        req_ready, rsp_valid, rsp_fault, mem_req;
    logic [31:0] rsp_phys, mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_data = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rd_cnt = 0;
    int rsp_cyc = -1;
    logic [19:0] cur_base = '0;
    logic [31:0] pmem [logic [31:0]];
    logic [31:0] rd_log [$];
    logic [31:0] q_phys [$];
    logic        q_fault [$];
    string       q_tag [$];

    pgx_translator u_pgx_translator (
        .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .dir_base_wr(dir_base_wr),
        .dir_base_in(dir_base_in), .flush(flush), .req_valid(req_valid),
        .req_lin(req_lin), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_phys(rsp_phys), .rsp_fault(rsp_fault), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return pmem.exists(a) ? pmem[a] : 32'h0;
    endfunction

    // Reference walk over the bench's own tables.
    function automatic void ref_xlate(input logic [31:0] lin, input logic [19:0] base,
                                      output logic [31:0] phys, output logic fault);
        logic [31:0] pde, pte;
        pde = rd({base, lin[31:22], 2'b00});
        phys = '0;
        fault = 1'b1;
        if (pde[0]) begin
            pte = rd({pde[31:12], lin[21:12], 2'b00});
            if (pte[0]) begin
                phys = {pte[31:12], lin[11:0]};
                fault = 1'b0;
            end
        end
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: acknowledges one read per request, a cycle or so later.
    always @(negedge clk) begin
        if (mem_ack) mem_ack <= 1'b0;
        else if (mem_req) begin
            mem_ack  <= 1'b1;
            mem_data <= rd(mem_addr);
            rd_log.push_back(mem_addr);
            rd_cnt   <= rd_cnt + 1;
        end
    end

    // Monitor: pops the scoreboard and compares each response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            rsp_cyc <= cyc;
            if (q_phys.size() == 0) begin
                chk(1'b0, "R4 unexpected response", rsp_phys, 32'h0);
            end else begin
                logic [31:0] ep;
                logic        ef;
                string       t;
                ep = q_phys.pop_front();
                ef = q_fault.pop_front();
                t  = q_tag.pop_front();
                chk(rsp_phys == ep, {t, " phys"}, rsp_phys, ep);
                chk(rsp_fault == ef, {t, " fault"}, 32'(rsp_fault), 32'(ef));
            end
        end
    end

    task automatic pulse(input bit is_base, input logic [19:0] val);
        @(posedge clk); #1;
        if (is_base) begin
            dir_base_wr = 1'b1;
            dir_base_in = val;
            cur_base = val;
        end else flush = 1'b1;
        @(posedge clk); #1;
        dir_base_wr = 1'b0;
        flush = 1'b0;
    endtask

    // Driver: computes the expectation, pushes it, issues the request,
    // then checks read count, same-cycle latency and ready gating.
    task automatic send(input logic [31:0] lin, input int exp_reads, input string tag);
        logic [31:0] ep;
        logic        ef;
        int          r0, acc, n;
        if (xlate_en) ref_xlate(lin, cur_base, ep, ef);
        else begin ep = lin; ef = 1'b0; end
        q_phys.push_back(ep); q_fault.push_back(ef); q_tag.push_back(tag);
        rd_log.delete();
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_lin = lin;
        r0 = rd_cnt;
        do @(negedge clk); while (!req_ready);
        acc = cyc;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        if (exp_reads > 0) chk(!req_ready, {tag, " R10 ready low during walk"}, 32'(req_ready), 0);
        n = 0;
        while (q_phys.size() != 0 && n < 60) begin @(negedge clk); n++; end
        chk(q_phys.size() == 0, {tag, " response arrived"}, q_phys.size(), 0);
        chk(rd_cnt - r0 == exp_reads, {tag, " read count"}, rd_cnt - r0, exp_reads);
        if (exp_reads == 0) chk(rsp_cyc == acc, {tag, " same-cycle answer"}, rsp_cyc, acc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Frame 0x00010: directory entry 0 -> table at 0x20000; entry 1 absent.
        pmem[32'h0001_0000] = 32'h0002_0003;
        for (int i = 0; i <= 40; i++) pmem[32'h0002_0000 + 4 * i] = {20'h00100 + 20'(i), 12'h007};
        pmem[32'h0002_0000 + 4 * 50] = 32'h0030_0006;
        // Frame 0x00030: directory entry 0 -> table at 0x40000.
        pmem[32'h0003_0000] = 32'h0004_0001;
        for (int i = 0; i <= 4; i++) pmem[32'h0004_0000 + 4 * i] = {20'h00200 + 20'(i), 12'h001};

        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 reset no response", 32'(rsp_valid), 0);
        chk(mem_req == 1'b0, "R1 reset no read", 32'(mem_req), 0);
        @(posedge clk); #1 rst_n = 1'b1;

        send(32'h1234_5678, 0, "R2 pass-through");
        pulse(1'b1, 20'h00010);
        xlate_en = 1'b1;

        send(32'h0000_0ABC, 2, "R1 R4 first miss page 0");
        chk(rd_log.size() == 2 && rd_log[0] == 32'h0001_0000, "R3 directory address", rd_log[0], 32'h0001_0000);
        chk(rd_log.size() == 2 && rd_log[1] == 32'h0002_0000, "R3 table address", rd_log[1], 32'h0002_0000);
        send(32'h0000_0FFF, 0, "R5 hit top of page 0");
        send(32'h0000_0000, 0, "R5 hit base of page 0");
        send(32'h0000_5010, 2, "R4 miss page 5");
        chk(rd_log.size() == 2 && rd_log[1] == 32'h0002_0014, "R3 table index", rd_log[1], 32'h0002_0014);
        send(32'h0000_5FF0, 0, "R5 hit page 5");

        send(32'h0040_0123, 1, "R6 directory absent");
        send(32'h0040_0123, 1, "R6 directory absent repeat");
        send(32'h0003_2044, 2, "R6 table absent");
        send(32'h0003_2044, 2, "R6 table absent repeat");

        xlate_en = 1'b0;
        send(32'h0000_7004, 0, "R2 pass-through page 7");
        xlate_en = 1'b1;
        send(32'h0000_7004, 2, "R2 no fill while off");

        pulse(1'b0, '0);
        send(32'h0000_0100, 2, "R8 miss after flush");

        pulse(1'b0, '0);
        for (int i = 0; i < 32; i++) send({20'(i), 12'h010}, 2, "R7 fill");
        send(32'h0000_0020, 0, "R7 touch page 0");
        send(32'h0002_0030, 2, "R7 page 32 evicts");
        send(32'h0000_0040, 0, "R7 page 0 kept");
        send(32'h0000_1050, 2, "R7 page 1 evicted");

        pulse(1'b1, 20'h00030);
        send(32'h0000_0ABC, 2, "R9 new frame");
        chk(rd_log.size() == 2 && rd_log[0] == 32'h0003_0000, "R9 directory address", rd_log[0], 32'h0003_0000);
        send(32'h0000_0ABD, 0, "R9 hit after refill");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule